// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block is the central grant controller for a split-transaction system bus shared by `N` function units. Each unit has four dedicated lines to the arbiter:

- an answer request line, which has high priority;
- an order request line, which has low priority;
- an end-of-transfer line;
- a grant line.

The arbiter samples all requests on each clock edge. It picks one unit and asserts that unit's grant. It keeps the grant asserted until the transfer is complete. It then hands the bus to the next winner with no idle cycle between the two transfers.

A pending answer request always beats any order request. Among requests of equal priority, the winner is chosen round-robin, starting from the unit after the most recently granted one. While the shared lock line is asserted, order requests are not granted, but answer requests still are.

The arbiter learns the transfer length from the end-of-transfer line:

- If that line is low-asserted together with the request, the transfer is multi-cycle. The master keeps the line asserted and releases it shortly before its data ends.
- If the line is not asserted with the request, the transfer takes a single cycle.

All unit-facing lines are active low. The clock input is expected to be the inverted bus clock, so that the arbiter's rising edge matches the bus's falling edge. Reset is synchronous and active high.

Top module: `split_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after a reset edge, every grant line is high (negated). This holds even if a grant was active when reset arrived.
- R2: At most one grant line is low in any cycle.
- R3: When no grant is active and a grantable request is present in cycle c, exactly one grant is low in cycle c+1. A grantable request is an answer request, or an order request with the lock negated.
- R4: If any answer request is present when a winner is chosen, the grant goes to an answer requester, never to an order requester.
- R5: While lock_n is low, no order request is granted and the grants stay negated for such requests. An answer request seen in the same cycle is still granted in the next cycle.
- R6: Among requests of the same priority, the winner is the first requesting unit found by counting upward (modulo N) from the unit granted last. After reset, the search starts at unit 0.
- R7: A request whose end-of-transfer line is high (negated) in its request cycle receives a grant that lasts exactly one cycle.
- R8: A request whose end-of-transfer line is low in its request cycle receives a grant that stays low in every cycle in which that unit still holds end-of-transfer low. The grant also stays low for exactly one cycle after the first granted cycle in which the line is high.
- R9: If another grantable request is pending in the last granted cycle of a transfer, the new grant is low in the very next cycle, with no idle cycle in between.
- R10: A request line that the current master still holds low during its final granted cycle is not taken as a new request. Grants are negated next if nobody else requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge, fed from the inverted bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_hi_n | input | N | Per-unit answer request, active low |
| req_lo_n | input | N | Per-unit order request, active low |
| eot_n | input | N | Per-unit end-of-transfer notice, active low |
| lock_n | input | 1 | Shared bus lock, active low |
| grant_n | output | N | Per-unit bus grant, active low |

## Verification
Two decisions meet in the same cycle at the edge that closes a transfer. One is the release of the current grant, driven by the end-of-transfer countdown. The other is the choice of the next winner, driven by priority, lock and the round-robin pointer.

The bench provokes this overlap by keeping order requests waiting behind a multi-cycle answer transfer. It also does so by having several units request while the previous single-cycle grant is still in its only cycle. For each such case, the bench judges that the old grant drops and the expected new unit rises in the very next cycle.

The lock case checks the same edge from the other side. An answer request must be granted while waiting order requests stay blocked. The bench then confirms that the order requests are granted once the lock clears.

// File: rtl/split_bus_arbiter_pkg.sv
package split_bus_arbiter_pkg;

    // Arbiter phase: nobody granted, grant held while end-of-transfer is low,
    // final granted cycle (next winner is chosen at its closing edge).
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_HOLD = 2'd1,
        ARB_LAST = 2'd2
    } arb_phase_e;

    // Source of the decision taken at an arbitration edge.
    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_ANSW  = 2'd1,
        WIN_ORDER = 2'd2
    } win_src_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/arb_req_front.sv
module arb_req_front #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] req_hi_n,
    input  logic [N-1:0] req_lo_n,
    input  logic [N-1:0] eot_n,
    input  logic         lock_n,
    input  logic [N-1:0] owner_mask,
    output logic [N-1:0] hi_elig,
    output logic [N-1:0] lo_elig,
    output logic [N-1:0] eot_act
);
    // Active-low lines are turned into active-high eligibility.
    // The current master's stale request is masked out.
    // Lock suppresses only order requests.
    always_comb begin
        hi_elig = ~req_hi_n & ~owner_mask;
        lo_elig = lock_n ? (~req_lo_n & ~owner_mask) : '0;
        eot_act = ~eot_n;
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last_idx,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int k = 1; k <= int'(N); k++) begin
            int cand;
            cand = (int'(last_idx) + k) % int'(N);
            if (!valid && req[IW'(cand)]) begin
                valid = 1'b1;
                idx   = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
    import split_bus_arbiter_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hi_valid,
    input  logic [IW-1:0] hi_idx,
    input  logic          lo_valid,
    input  logic [IW-1:0] lo_idx,
    input  logic [N-1:0]  eot_act,
    output logic [IW-1:0] last_idx,
    output logic [N-1:0]  owner_mask,
    output logic [N-1:0]  grant_act
);
    localparam logic [IW-1:0] RESET_LAST = IW'(N - 1);

    arb_phase_e    phase;
    logic [IW-1:0] owner;
    win_src_e      win;
    logic [IW-1:0] win_idx;

    always_comb begin
        if (hi_valid) begin
            win     = WIN_ANSW;
            win_idx = hi_idx;
        end else if (lo_valid) begin
            win     = WIN_ORDER;
            win_idx = lo_idx;
        end else begin
            win     = WIN_NONE;
            win_idx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ARB_IDLE;
            owner    <= '0;
            last_idx <= RESET_LAST;
        end else begin
            case (phase)
                ARB_HOLD: begin
                    if (!eot_act[owner]) phase <= ARB_LAST;
                end
                default: begin
                    if (win != WIN_NONE) begin
                        owner    <= win_idx;
                        last_idx <= win_idx;
                        phase    <= eot_act[win_idx] ? ARB_HOLD : ARB_LAST;
                    end else begin
                        phase <= ARB_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        grant_act  = (phase != ARB_IDLE) ? (N'(1) << owner) : '0;
        owner_mask = grant_act;
    end
endmodule

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter
    import split_bus_arbiter_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_hi_n,
    input  logic [N-1:0] req_lo_n,
    input  logic [N-1:0] eot_n,
    input  logic         lock_n,
    output logic [N-1:0] grant_n
);
    localparam int unsigned IW = idx_width(N);

    logic [N-1:0]  hi_elig, lo_elig, eot_act, owner_mask, grant_act;
    logic [IW-1:0] last_idx, hi_idx, lo_idx;
    logic          hi_valid, lo_valid;

    arb_req_front #(.N(N)) front_i (
        .req_hi_n  (req_hi_n),
        .req_lo_n  (req_lo_n),
        .eot_n     (eot_n),
        .lock_n    (lock_n),
        .owner_mask(owner_mask),
        .hi_elig   (hi_elig),
        .lo_elig   (lo_elig),
        .eot_act   (eot_act)
    );

    arb_rr_pick #(.N(N), .IW(IW)) pick_hi_i (
        .req     (hi_elig),
        .last_idx(last_idx),
        .valid   (hi_valid),
        .idx     (hi_idx)
    );

    arb_rr_pick #(.N(N), .IW(IW)) pick_lo_i (
        .req     (lo_elig),
        .last_idx(last_idx),
        .valid   (lo_valid),
        .idx     (lo_idx)
    );

    arb_grant_fsm #(.N(N), .IW(IW)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .hi_valid  (hi_valid),
        .hi_idx    (hi_idx),
        .lo_valid  (lo_valid),
        .lo_idx    (lo_idx),
        .eot_act   (eot_act),
        .last_idx  (last_idx),
        .owner_mask(owner_mask),
        .grant_act (grant_act)
    );

    assign grant_n = ~grant_act;
endmodule

// File: rtl/split_bus_arbiter_chk.sv
module split_bus_arbiter_chk #(
    parameter int unsigned N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req_hi_n,
    input logic [N-1:0] req_lo_n,
    input logic [N-1:0] eot_n,
    input logic         lock_n,
    input logic [N-1:0] grant_n
);
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (&grant_n));

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~grant_n));

    p_idle_serves_r3: assert property (@(posedge clk) disable iff (rst)
        ((&grant_n) && ((|(~req_hi_n)) || ((|(~req_lo_n)) && lock_n)))
        |=> !(&grant_n));

    p_answer_first_r4: assert property (@(posedge clk) disable iff (rst)
        ((&grant_n) && (|(~req_hi_n)))
        |=> ((~grant_n & ~$past(req_hi_n)) != '0));

    p_lock_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        ((&grant_n) && !lock_n && (&req_hi_n)) |=> (&grant_n));

    for (genvar u = 0; u < N; u++) begin : g_unit
        p_hold_on_eot_r8: assert property (@(posedge clk) disable iff (rst)
            (!grant_n[u] && !eot_n[u]) |=> !grant_n[u]);

        p_tail_cycle_r8: assert property (@(posedge clk) disable iff (rst)
            (!grant_n[u] && eot_n[u] && $past(!grant_n[u]) && $past(!eot_n[u]))
            |=> !grant_n[u]);

        p_release_r8: assert property (@(posedge clk) disable iff (rst)
            (!grant_n[u] && eot_n[u] && $past(!grant_n[u]) && $past(eot_n[u]))
            |=> grant_n[u]);
    end
endmodule

bind split_bus_arbiter split_bus_arbiter_chk #(.N(N)) chk_i (.*);

// File: tb/split_bus_arbiter_tb_top.sv
module split_bus_arbiter_tb_top;
    localparam int unsigned N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_hi_n = '1, req_lo_n = '1, eot_n = '1;
    logic         lock_n = 1'b1;
    logic [N-1:0] grant_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    split_bus_arbiter #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .req_hi_n(req_hi_n), .req_lo_n(req_lo_n),
        .eot_n(eot_n), .lock_n(lock_n), .grant_n(grant_n)
    );

    typedef struct packed {
        logic [3:0] hi;
        logic [3:0] lo;
        logic [3:0] eot;
        logic       lock;
        logic [3:0] exp;
        logic [3:0] rq;
    } vec_t;

    // Row k: inputs driven in cycle k, grant expected in cycle k (from row k-1).
    localparam vec_t VT [22] = '{
        '{4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'd1},  // R1 idle after reset
        '{4'b0000, 4'b0110, 4'b0000, 1'b0, 4'b0000, 4'd1},  // R1
        '{4'b0000, 4'b0100, 4'b0000, 1'b0, 4'b0010, 4'd3},  // R3 / R6 start at unit 0 side
        '{4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0100, 4'd9},  // R9 back-to-back
        '{4'b1000, 4'b0001, 4'b1000, 1'b0, 4'b0000, 4'd7},  // R7 single-cycle dropped
        '{4'b0000, 4'b0001, 4'b1000, 1'b0, 4'b1000, 4'd4},  // R4 answer wins
        '{4'b0000, 4'b0001, 4'b0000, 1'b0, 4'b1000, 4'd8},  // R8 held while eot low
        '{4'b0000, 4'b0001, 4'b0000, 1'b0, 4'b1000, 4'd8},  // R8 tail cycle
        '{4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001, 4'd9},  // R9 no gap
        '{4'b0000, 4'b0110, 4'b0000, 1'b1, 4'b0000, 4'd7},  // R7
        '{4'b0001, 4'b0110, 4'b0000, 1'b1, 4'b0000, 4'd5},  // R5 lock blocks order
        '{4'b0000, 4'b0110, 4'b0000, 1'b1, 4'b0001, 4'd5},  // R5 answer under lock
        '{4'b0000, 4'b0110, 4'b0000, 1'b0, 4'b0000, 4'd5},  // R5 still blocked
        '{4'b0000, 4'b0100, 4'b0000, 1'b0, 4'b0010, 4'd6},  // R6 after unit 0
        '{4'b0000, 4'b1011, 4'b0000, 1'b0, 4'b0100, 4'd9},  // R9
        '{4'b0000, 4'b0011, 4'b0000, 1'b0, 4'b1000, 4'd6},  // R6 skips 0,1 for 3
        '{4'b0000, 4'b0010, 4'b0000, 1'b0, 4'b0001, 4'd6},  // R6 wrap
        '{4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0010, 4'd6},  // R6
        '{4'b0110, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'd7},  // R7
        '{4'b0010, 4'b0000, 4'b0000, 1'b0, 4'b0100, 4'd6},  // R6 answer round-robin
        '{4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0010, 4'd6},  // R6
        '{4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'd7}   // R7
    };

    task automatic check_grant(input logic [3:0] exp, input string tag);
        logic [3:0] got;
        got = ~grant_n;
        total++;
        if (got !== exp || $countones(got) > 1) begin
            bad++;
            $display("FAIL %s grant got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] hi, input logic [3:0] lo,
                         input logic [3:0] eot, input logic lock);
        req_hi_n = ~hi;
        req_lo_n = ~lo;
        eot_n    = ~eot;
        lock_n   = ~lock;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        drive(4'b0, 4'b0, 4'b0, 1'b0);
        repeat (3) step();
        check_grant(4'b0000, "R1");
        rst = 1'b0;

        for (int r = 0; r < 22; r++) begin
            check_grant(VT[r].exp, $sformatf("R%0d row %0d", VT[r].rq, r));
            drive(VT[r].hi, VT[r].lo, VT[r].eot, VT[r].lock);
            step();
        end

        // R10: master keeps its request during its only granted cycle
        drive(4'b0000, 4'b0001, 4'b0000, 1'b0);
        step();
        check_grant(4'b0001, "R3");
        step();
        check_grant(4'b0000, "R10");
        drive(4'b0000, 4'b0000, 4'b0000, 1'b0);
        step();
        check_grant(4'b0000, "R10");

        // R8 long transfer with an order request waiting (R9)
        drive(4'b0100, 4'b0001, 4'b0100, 1'b0);
        step();
        for (int j = 0; j < 5; j++) begin
            check_grant(4'b0100, "R8");
            drive(4'b0000, 4'b0001, 4'b0100, 1'b0);
            step();
        end
        drive(4'b0000, 4'b0001, 4'b0000, 1'b0);
        check_grant(4'b0100, "R8");
        step();
        check_grant(4'b0100, "R8");
        step();
        check_grant(4'b0001, "R9");
        drive(4'b0000, 4'b0000, 4'b0000, 1'b0);
        step();
        check_grant(4'b0000, "R7");

        // R1: reset arrives in the middle of a multi-cycle grant
        drive(4'b0000, 4'b0010, 4'b0010, 1'b0);
        step();
        check_grant(4'b0010, "R3");
        rst = 1'b1;
        drive(4'b0000, 4'b0000, 4'b0010, 1'b0);
        step();
        check_grant(4'b0000, "R1");
        rst = 1'b0;
        drive(4'b0000, 4'b0000, 4'b0000, 1'b0);
        step();
        check_grant(4'b0000, "R1");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule